// File: doc/BRIEF.md
# Indexed Effective Address Calculator

This block forms the operand address for the "address register indirect with index and 8-bit displacement" mode. It adds three values: the base address register, the signed low byte of the brief extension word, and an index register. The block reads the index register through a register-file read port that it drives itself. The extension word chooses the register and whether the full register or only its sign-extended low half is used. The scale field of the extension word has no effect, so the index is always added unscaled.

The result is registered. The block returns the 32-bit sum and the 24-bit bus address, which is the low 24 bits of the sum. When a word or long access lands on an odd address, it raises an address-error flag. It also latches the full 32-bit sum as the faulting address, so that exception handling can use it. Instruction decode and bus sequencing are outside this block.

Top module: `ea_idx_calc`

## Requirements
- R1: When `valid_i` is high, `sum_o` becomes `base_i + sext32(ext_word_i[7:0]) + index` one clock later, taken modulo 2^32.
- R2: `rd_sel_o` equals `ext_word_i[15:12]` combinationally. Values 0 to 7 select data registers and values 8 to 15 select address registers. `rd_data_i` is the content of the selected register.
- R3: If `ext_word_i[11]` is 1, the index is the whole of `rd_data_i`. If it is 0, the index is `rd_data_i[15:0]` sign-extended to 32 bits.
- R4: `ext_word_i[10:8]`, which includes the scale field in bits 10:9, has no effect on any output.
- R5: `bus_addr_o` equals `sum_o[23:0]` for every result.
- R6: `size_i` encodes the operand size: 00 is byte, 01 is word, 10 is long, and 11 is treated as long. `addr_err_o` is set one cycle after a valid request whose size is not byte and whose sum has bit 0 set.
- R7: A byte-size request never raises `addr_err_o`, whatever its address.
- R8: `fault_addr_o` loads the full 32-bit sum only on a request that raises an address error. At all other times it keeps its value.
- R9: `valid_o` follows `valid_i` with a delay of one clock. A cycle without `valid_i` clears `valid_o` and `addr_err_o` in the next cycle, and leaves `sum_o` and `bus_addr_o` unchanged.
- R10: While `rst_ni` is low, all registered outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request strobe |
| base_i | input | 32 | Base address register value |
| ext_word_i | input | 16 | Brief extension word |
| size_i | input | 2 | Operand size: 00 byte, 01 word, 10 long, 11 long |
| rd_sel_o | output | 4 | Register-file read select for the index register |
| rd_data_i | input | 32 | Register-file read data |
| valid_o | output | 1 | Result valid |
| sum_o | output | 32 | Full 32-bit effective address |
| bus_addr_o | output | 24 | Bus address, the low 24 bits of the sum |
| addr_err_o | output | 1 | Address error: word or long access at an odd address |
| fault_addr_o | output | 32 | Last faulting 32-bit address |

## Verification
The register select on `rd_sel_o` is combinational, so the bench checks it shortly after it drives the extension word, before the next clock edge. Every other result is due exactly one rising edge after the request. The bench drives each request on a falling edge and compares the outputs on the following falling edge, which gives one vector per cycle.

The bench sweeps every value of extension bits 15:11, all scale values and all four size codes, together with several boundary displacements. After a request, a cycle with `valid_i` low confirms that the results are held and that the error flag is cleared.

// File: rtl/ea_idx_pkg.sv
package ea_idx_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned BUS_W   = 24;
  localparam int unsigned EXT_W   = 16;
  localparam int unsigned DISP_W  = 8;
  localparam int unsigned SHORT_W = 16;
  localparam int unsigned SEL_W   = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } op_size_e;
endpackage

// File: rtl/ea_index_sel.sv
module ea_index_sel #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned SHORT_W = 16,
  parameter int unsigned SEL_W   = 4
) (
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              long_i,
  output logic [SEL_W-1:0]  rd_sel_o,
  input  logic [ADDR_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] index_o
);
  localparam int unsigned EXT_BITS = ADDR_W - SHORT_W;

  logic [ADDR_W-1:0] short_ext;

  assign rd_sel_o = sel_i;

  generate
    if (EXT_BITS > 0) begin : g_ext
      assign short_ext = {{EXT_BITS{rd_data_i[SHORT_W-1]}}, rd_data_i[SHORT_W-1:0]};
    end else begin : g_noext
      assign short_ext = rd_data_i;
    end
  endgenerate

  assign index_o = long_i ? rd_data_i : short_ext;
endmodule

// File: rtl/ea_adder.sv
module ea_adder #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DISP_W = 8
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [ADDR_W-1:0] index_i,
  output logic [ADDR_W-1:0] sum_o
);
  logic [ADDR_W-1:0] disp_ext;

  assign disp_ext = {{(ADDR_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
  assign sum_o    = base_i + disp_ext + index_i;
endmodule

// File: rtl/ea_align_chk.sv
module ea_align_chk
  import ea_idx_pkg::*;
(
  input  logic [1:0] size_i,
  input  logic       addr_lsb_i,
  output logic       misalign_o
);
  op_size_e sz;

  assign sz = op_size_e'(size_i);

  always_comb begin
    unique case (sz)
      SZ_BYTE: misalign_o = 1'b0;
      SZ_WORD, SZ_LONG, SZ_RSVD: misalign_o = addr_lsb_i;
      default: misalign_o = addr_lsb_i;
    endcase
  end
endmodule

// File: rtl/ea_idx_calc.sv
module ea_idx_calc
  import ea_idx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [EXT_W-1:0]  ext_word_i,
  input  logic [1:0]        size_i,
  output logic [SEL_W-1:0]  rd_sel_o,
  input  logic [ADDR_W-1:0] rd_data_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] sum_o,
  output logic [BUS_W-1:0]  bus_addr_o,
  output logic              addr_err_o,
  output logic [ADDR_W-1:0] fault_addr_o
);
  logic [ADDR_W-1:0] index_w;
  logic [ADDR_W-1:0] sum_w;
  logic              misalign_w;
  logic [2:0]        unused_ext;

  // bits 10:8 carry scale and reserved fields; not used on this generation
  assign unused_ext = ext_word_i[10:8];

  ea_index_sel #(
    .ADDR_W (ADDR_W),
    .SHORT_W(SHORT_W),
    .SEL_W  (SEL_W)
  ) u_index_sel (
    .sel_i    (ext_word_i[EXT_W-1 -: SEL_W]),
    .long_i   (ext_word_i[EXT_W-1-SEL_W]),
    .rd_sel_o (rd_sel_o),
    .rd_data_i(rd_data_i),
    .index_o  (index_w)
  );

  ea_adder #(
    .ADDR_W(ADDR_W),
    .DISP_W(DISP_W)
  ) u_adder (
    .base_i (base_i),
    .disp_i (ext_word_i[DISP_W-1:0]),
    .index_i(index_w),
    .sum_o  (sum_w)
  );

  ea_align_chk u_align (
    .size_i    (size_i),
    .addr_lsb_i(sum_w[0]),
    .misalign_o(misalign_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      sum_o        <= '0;
      bus_addr_o   <= '0;
      addr_err_o   <= 1'b0;
      fault_addr_o <= '0;
    end else begin
      valid_o    <= valid_i;
      addr_err_o <= valid_i & misalign_w;
      if (valid_i) begin
        sum_o      <= sum_w;
        bus_addr_o <= sum_w[BUS_W-1:0];
        if (misalign_w) fault_addr_o <= sum_w;
      end
    end
  end
endmodule

// File: rtl/ea_idx_calc_chk.sv
module ea_idx_calc_chk
  import ea_idx_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [EXT_W-1:0]  ext_word_i,
  input logic [1:0]        size_i,
  input logic [SEL_W-1:0]  rd_sel_o,
  input logic              valid_o,
  input logic [ADDR_W-1:0] sum_o,
  input logic [BUS_W-1:0]  bus_addr_o,
  input logic              addr_err_o,
  input logic [ADDR_W-1:0] fault_addr_o
);
  a_r2_sel_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_sel_o == ext_word_i[EXT_W-1 -: SEL_W]);

  a_r5_bus_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_addr_o == sum_o[BUS_W-1:0]);

  a_r6_err_odd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_err_o |-> (sum_o[0] && valid_o));

  a_r7_byte_no_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i == SZ_BYTE) |=> !addr_err_o);

  a_r8_fault_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_err_o |-> fault_addr_o == sum_o);

  a_r8_fault_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(fault_addr_o));

  a_r9_valid_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !addr_err_o && $stable(sum_o)));
endmodule

bind ea_idx_calc ea_idx_calc_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .ext_word_i  (ext_word_i),
  .size_i      (size_i),
  .rd_sel_o    (rd_sel_o),
  .valid_o     (valid_o),
  .sum_o       (sum_o),
  .bus_addr_o  (bus_addr_o),
  .addr_err_o  (addr_err_o),
  .fault_addr_o(fault_addr_o)
);

// File: tb/ea_idx_calc_bench.sv
`timescale 1ns/1ps
module ea_idx_calc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] base = '0;
  logic [15:0] ext = '0;
  logic [1:0]  size = '0;
  logic [3:0]  rd_sel;
  logic [31:0] rd_data;
  logic        valid_q;
  logic [31:0] sum;
  logic [23:0] bus_addr;
  logic        addr_err;
  logic [31:0] fault_addr;

  logic [31:0] rf [16];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_fault = '0;

  always #5 clk = ~clk;

  assign rd_data = rf[rd_sel];

  ea_idx_calc u_ea_idx_calc (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .valid_i     (valid),
    .base_i      (base),
    .ext_word_i  (ext),
    .size_i      (size),
    .rd_sel_o    (rd_sel),
    .rd_data_i   (rd_data),
    .valid_o     (valid_q),
    .sum_o       (sum),
    .bus_addr_o  (bus_addr),
    .addr_err_o  (addr_err),
    .fault_addr_o(fault_addr)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] model_sum(input logic [31:0] b, input logic [15:0] e,
                                            input logic [31:0] r);
    logic [31:0] idx;
    logic [31:0] d;
    idx = e[11] ? r : {{16{r[15]}}, r[15:0]};
    d   = {{24{e[7]}}, e[7:0]};
    return b + d + idx;
  endfunction

  // drive at negedge, results due after the next posedge, sampled at the next negedge
  task automatic run_vec(input logic [31:0] b, input logic [15:0] e, input logic [1:0] s);
    logic [31:0] es;
    logic        eerr;
    base  = b;
    ext   = e;
    size  = s;
    valid = 1'b1;
    #1;
    chk("R2 rd_sel", {28'd0, rd_sel}, {28'd0, e[15:12]});
    es   = model_sum(b, e, rf[e[15:12]]);
    eerr = (s != 2'b00) && es[0];
    if (eerr) exp_fault = es;
    @(negedge clk);
    chk(e[11] ? "R1 R3 sum long index" : "R1 R3 sum short index", sum, es);
    chk("R5 bus_addr", {8'd0, bus_addr}, {8'd0, es[23:0]});
    chk(s == 2'b00 ? "R7 byte err" : "R6 err", {31'd0, addr_err}, {31'd0, eerr});
    chk("R8 fault_addr", fault_addr, exp_fault);
    chk("R9 valid_o", {31'd0, valid_q}, 32'd1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] disps [6];
    logic [31:0] hold_sum;
    logic [31:0] sums_r4 [4];
    disps[0] = 8'h00; disps[1] = 8'h7F; disps[2] = 8'h80;
    disps[3] = 8'hFF; disps[4] = 8'h4F; disps[5] = 8'h01;
    for (int n = 0; n < 16; n++) rf[n] = (32'h9E3779B9 * (n + 1)) ^ (32'h00018000 * n);
    rf[0] = 32'hA1E940B7;

    repeat (3) @(negedge clk);
    chk("R10 reset valid_o", {31'd0, valid_q}, 32'd0);
    chk("R10 reset sum", sum, 32'd0);
    chk("R10 reset bus", {8'd0, bus_addr}, 32'd0);
    chk("R10 reset err", {31'd0, addr_err}, 32'd0);
    chk("R10 reset fault", fault_addr, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // worked example: base 3E4D4A5B, ext 0C4F, long index D0, long access
    run_vec(32'h3E4D4A5B, 16'h0C4F, 2'b10);
    chk("R1 example sum", sum, 32'hE0368B61);
    chk("R5 example bus", {8'd0, bus_addr}, 32'h00368B61);
    chk("R6 example err", {31'd0, addr_err}, 32'd1);

    // idle cycle holds results and clears flags
    hold_sum = sum;
    valid = 1'b0;
    base  = 32'h12345678;
    ext   = 16'hF801;
    @(negedge clk);
    chk("R9 idle valid_o", {31'd0, valid_q}, 32'd0);
    chk("R9 idle err", {31'd0, addr_err}, 32'd0);
    chk("R9 idle sum hold", sum, hold_sum);
    chk("R8 idle fault hold", fault_addr, exp_fault);

    // R4: scale and bits 10:8 must not change the result
    for (int sc = 0; sc < 4; sc++) begin
      run_vec(32'h00102031, {4'h9, 1'b0, sc[1:0], 1'b1, 8'h85}, 2'b01);
      sums_r4[sc] = sum;
    end
    for (int sc = 1; sc < 4; sc++) chk("R4 scale ignored", sums_r4[sc], sums_r4[0]);

    // sweep: bits 15:11, displacements, scale/bit8, all size codes
    for (int hi = 0; hi < 32; hi++)
      for (int di = 0; di < 6; di++)
        for (int sc = 0; sc < 4; sc++)
          for (int sz = 0; sz < 4; sz++)
            run_vec(32'h3E4D4A5B + 32'h01010101 * (hi * 6 + di) + sz,
                    {hi[4:0], sc[1:0], di[0], disps[di]}, sz[1:0]);

    valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule